// File: doc/BRIEF.md
# Store-and-Forward Event Buffer

This block is a dual-clock buffer placed between event-building logic and a high-speed serial link core. The writer pushes 32-bit words in its own clock domain and flags the final word of each event; the link side pulls words in a separate transceiver clock domain. A word is never offered to the reader until the event it belongs to has been written in full, so the link can send an event without stalling partway through.

Each stored entry holds the data word plus an end marker. Two counters, one per domain, track how many complete events have been written and how many have been read. Both these counters and the word pointers cross between the domains as Gray codes through two-flop synchronizers. The reader sees an event-ready flag whenever the synchronized count of written events is ahead of its own count, and it sees an end-of-event flag alongside the final word of each event. When the buffer fills before an event is closed, the event is cut short. The last word that fit is stored with the end marker set, a sticky overflow flag goes high, and the rest of that event is thrown away.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset, rd_empty_o is 1, and wr_full_o, ev_ready_o, rd_valid_o and overflow_o are all 0.
- R2: Words come out on rd_data_o in the order they were accepted, with all 32 bits unchanged.
- R3: While the event being written has not yet received its last word, its stored words are never offered: rd_valid_o stays 0 while rd_empty_o is 0.
- R4: ev_ready_o is 1 whenever at least one complete event is stored. It returns to 0 once the end word of the last stored event has been read.
- R5: rd_eoe_o is 1 together with the final stored word of each event and is 0 for every other word.
- R6: wr_full_o is 1 when DEPTH words are stored. A write offered while full is ignored: its word is not stored and never appears on the read side.
- R7: If the write that fills the buffer carries a non-final word, that word is stored with the end marker set and overflow_o becomes 1. The remaining words of that event, up to and including the word the writer marked as final, are discarded.
- R8: Once set, overflow_o stays 1 until reset, and later events still pass through normally.
- R9: A read request made while rd_valid_o is 0 has no effect. No word is removed, and the next word delivered is still the oldest one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write (data) clock |
| rclk_i | input | 1 | Read (transceiver) clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Word to store |
| wr_last_i | input | 1 | Marks the final word of the event |
| wr_full_o | output | 1 | Buffer full, seen by the writer |
| overflow_o | output | 1 | Sticky flag: an event was truncated or a write was dropped |
| rd_en_i | input | 1 | Pop request; takes effect only while rd_valid_o is 1 |
| rd_data_o | output | 32 | Oldest stored word |
| rd_valid_o | output | 1 | rd_data_o belongs to a complete event and may be popped |
| rd_eoe_o | output | 1 | rd_data_o is the final word of its event |
| rd_empty_o | output | 1 | No words stored, seen by the reader |
| ev_ready_o | output | 1 | At least one complete event is stored |

## Verification
The hardest state to reach is a truncation whose outcome is fully determined. The fill point depends on the read pointer as seen by the write side, and that view lags behind the reader. The bench therefore drains the buffer, stops the reader and waits for the synchronizers to settle. It then writes an event longer than the buffer, which makes the exact word that receives the forced end marker predictable. A second event is then offered while the buffer is still full, and the bench checks that none of its words surface once reading resumes.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              last;
    logic [DATA_W-1:0] data;
  } sfb_entry_t;
endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sfb_ram.sv
module sfb_ram
  import sfb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  sfb_entry_t       wentry_i,
  input  logic [AW-1:0]    raddr_i,
  output sfb_entry_t       rentry_o
);
  sfb_entry_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wentry_i;
  end

  assign rentry_o = mem_q[raddr_i];
endmodule

// File: rtl/sfb_wr_ctrl.sv
module sfb_wr_ctrl #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_last_i,
  input  logic [PW-1:0] rptr_gray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          last_o,
  output logic [PW-1:0] wptr_gray_o,
  output logic [PW-1:0] wev_gray_o,
  output logic          full_o,
  output logic          overflow_o
);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  logic [PW-1:0] rbin, occ;
  logic [PW-1:0] wbin_q, wbin_d, wev_q, wev_d;
  logic [PW-1:0] wgray_q, wevg_q;
  logic          discard_q, ovf_q;
  logic          fills, accept, last_eff;

  always_comb begin
    rbin[PW-1] = rptr_gray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rptr_gray_i[i];
  end

  assign occ      = wbin_q - rbin;
  assign full_o   = (occ == DEPTH_V);
  assign fills    = (occ == DEPTH_V - 1'b1);
  assign accept   = wr_en_i && !full_o && !discard_q;
  // the word that fills the buffer closes the event
  assign last_eff = wr_last_i || fills;
  assign wbin_d   = wbin_q + {{AW{1'b0}}, accept};
  assign wev_d    = wev_q + {{AW{1'b0}}, accept && last_eff};

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q    <= '0;
      wev_q     <= '0;
      wgray_q   <= '0;
      wevg_q    <= '0;
      discard_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wev_q   <= wev_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      wevg_q  <= wev_d ^ (wev_d >> 1);
      if (accept) begin
        if (fills && !wr_last_i) begin
          discard_q <= 1'b1;
          ovf_q     <= 1'b1;
        end
      end else if (wr_en_i) begin
        if (discard_q) begin
          if (wr_last_i) discard_q <= 1'b0;
        end else begin
          ovf_q     <= 1'b1;
          discard_q <= !wr_last_i;
        end
      end
    end
  end

  assign we_o        = accept;
  assign waddr_o     = wbin_q[AW-1:0];
  assign last_o      = last_eff;
  assign wptr_gray_o = wgray_q;
  assign wev_gray_o  = wevg_q;
  assign overflow_o  = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R8
  AST_OCC_BOUND: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    occ <= DEPTH_V); // R6
  AST_FULL_HOLDS_PTR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |=> (wbin_q == $past(wbin_q))); // R6
  AST_TRUNC_FLAGS: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $rose(discard_q) |-> ovf_q); // R7
endmodule

// File: rtl/sfb_rd_ctrl.sv
module sfb_rd_ctrl #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          entry_last_i,
  input  logic [PW-1:0] wptr_gray_i,
  input  logic [PW-1:0] wev_gray_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rptr_gray_o,
  output logic          empty_o,
  output logic          ready_o,
  output logic          valid_o,
  output logic          eoe_o
);
  logic [PW-1:0] rbin_q, rbin_d, rev_q, rev_d;
  logic [PW-1:0] rgray_q, revg_q;
  logic          pop;

  assign empty_o = (rgray_q == wptr_gray_i);
  assign ready_o = (revg_q != wev_gray_i);
  // gate on both: pointer and event syncs may skew by a cycle in silicon
  assign valid_o = ready_o && !empty_o;
  assign eoe_o   = valid_o && entry_last_i;
  assign pop     = rd_en_i && valid_o;
  assign rbin_d  = rbin_q + {{AW{1'b0}}, pop};
  assign rev_d   = rev_q + {{AW{1'b0}}, pop && entry_last_i};

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rev_q   <= '0;
      rgray_q <= '0;
      revg_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rev_q   <= rev_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      revg_q  <= rev_d ^ (rev_d >> 1);
    end
  end

  assign raddr_o     = rbin_q[AW-1:0];
  assign rptr_gray_o = rgray_q;

  AST_READY_HAS_DATA: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ready_o |-> !empty_o); // R4
  AST_BLOCKED_READ: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && !valid_o) |=> (rbin_q == $past(rbin_q))); // R9
  AST_EOE_CLOSES: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (pop && entry_last_i) |=> (rev_q != $past(rev_q))); // R5
endmodule

// File: rtl/store_fwd_buf.sv
module store_fwd_buf
  import sfb_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              wr_full_o,
  output logic              overflow_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_eoe_o,
  output logic              rd_empty_o,
  output logic              ev_ready_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we, wlast;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr_g, wev_g, rptr_g;
  logic [PW-1:0] wptr_g_r, wev_g_r, rptr_g_w;
  sfb_entry_t    went, rent;

  assign went.data = wr_data_i;
  assign went.last = wlast;

  sfb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk_i      (wclk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_last_i   (wr_last_i),
    .rptr_gray_i (rptr_g_w),
    .we_o        (we),
    .waddr_o     (waddr),
    .last_o      (wlast),
    .wptr_gray_o (wptr_g),
    .wev_gray_o  (wev_g),
    .full_o      (wr_full_o),
    .overflow_o  (overflow_o)
  );

  sfb_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk_i   (wclk_i),
    .we_i     (we),
    .waddr_i  (waddr),
    .wentry_i (went),
    .raddr_i  (raddr),
    .rentry_o (rent)
  );

  sfb_sync #(.W(PW)) u_sync_wptr (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wptr_g), .q_o(wptr_g_r));
  sfb_sync #(.W(PW)) u_sync_wev  (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wev_g),  .q_o(wev_g_r));
  sfb_sync #(.W(PW)) u_sync_rptr (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rptr_g), .q_o(rptr_g_w));

  sfb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rclk_i       (rclk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .entry_last_i (rent.last),
    .wptr_gray_i  (wptr_g_r),
    .wev_gray_i   (wev_g_r),
    .raddr_o      (raddr),
    .rptr_gray_o  (rptr_g),
    .empty_o      (rd_empty_o),
    .ready_o      (ev_ready_o),
    .valid_o      (rd_valid_o),
    .eoe_o        (rd_eoe_o)
  );

  assign rd_data_o = rent.data;
endmodule

// File: tb/sim_store_fwd_buf.sv
module sim_store_fwd_buf;
  import sfb_pkg::*;

  localparam int DEPTH = 16;

  logic              wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic              wr_en = 1'b0, wr_last = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en_mon = 1'b0, rd_en_force = 1'b0;
  logic              wr_full, overflow, rd_valid, rd_eoe, rd_empty, ev_ready;
  logic [DATA_W-1:0] rd_data;
  bit                reader_on = 1'b0;
  int                n_chk = 0, n_fail = 0;
  sfb_entry_t        exp_q [$];

  always #10 wclk = ~wclk;  // 50 MHz
  always #7  rclk = ~rclk;

  store_fwd_buf #(.DEPTH(DEPTH)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_last_i(wr_last),
    .wr_full_o(wr_full), .overflow_o(overflow),
    .rd_en_i(rd_en_mon | rd_en_force), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_eoe_o(rd_eoe),
    .rd_empty_o(rd_empty), .ev_ready_o(ev_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // stored word: drive last flag ld, expect stored last flag le
  task automatic put(input logic [31:0] d, input logic ld, input logic le);
    sfb_entry_t e;
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d; wr_last = ld;
    e.data = d; e.last = le;
    exp_q.push_back(e);
    @(negedge wclk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic drop(input logic [31:0] d, input logic ld);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d; wr_last = ld;
    @(negedge wclk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic send_event(input int len, input logic [31:0] base);
    for (int i = 0; i < len; i++) put(base + i, i == len - 1, i == len - 1);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (10) @(negedge rclk);
  endtask

  // monitor / scoreboard
  always @(negedge rclk) begin
    if (!rst_ni) rd_en_mon <= 1'b0;
    else if (reader_on && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected word", rd_data, 0);
      end else begin
        sfb_entry_t e;
        e = exp_q.pop_front();
        chk(rd_data == e.data, "R2", "data order", rd_data, e.data);
        chk(rd_eoe == e.last, "R5", "end of event", rd_eoe, e.last);
      end
      rd_en_mon <= 1'b1;
    end else rd_en_mon <= 1'b0;
  end

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_ni = 1'b1;
    repeat (3) @(negedge rclk);
    // R1 reset state
    chk(rd_empty == 1'b1, "R1", "empty", rd_empty, 1);
    chk(wr_full == 1'b0, "R1", "full", wr_full, 0);
    chk(ev_ready == 1'b0, "R1", "ready", ev_ready, 0);
    chk(rd_valid == 1'b0, "R1", "valid", rd_valid, 0);
    chk(overflow == 1'b0, "R1", "overflow", overflow, 0);

    reader_on = 1'b1;
    // R3: partial event held back
    put(32'hA000_0000, 1'b0, 1'b0);
    put(32'hA000_0001, 1'b0, 1'b0);
    put(32'hA000_0002, 1'b0, 1'b0);
    repeat (10) @(negedge rclk);
    chk(rd_valid == 1'b0, "R3", "valid on partial", rd_valid, 0);
    chk(rd_empty == 1'b0, "R3", "words stored", rd_empty, 0);
    chk(ev_ready == 1'b0, "R4", "ready on partial", ev_ready, 0);
    // R9: read requests without a complete event
    rd_en_force = 1'b1;
    repeat (6) @(negedge rclk);
    rd_en_force = 1'b0;
    @(negedge rclk);
    chk(rd_empty == 1'b0, "R9", "words kept", rd_empty, 0);
    put(32'hA000_0003, 1'b1, 1'b1);  // scoreboard confirms oldest word first (R9)
    drain();
    chk(ev_ready == 1'b0, "R4", "ready after drain", ev_ready, 0);

    // varied event lengths, back to back
    send_event(1, 32'hB100_0000);
    send_event(5, 32'hB200_0000);
    send_event(1, 32'hB300_0000);
    send_event(12, 32'hB400_0000);
    send_event(2, 32'hFFFF_FFF0);
    send_event(7, 32'h5555_AAAA);
    drain();

    // R6 / R7: truncation with reader stopped
    reader_on = 1'b0;
    repeat (10) @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) put(32'hC000_0000 + i, 1'b0, i == DEPTH - 1);
    for (int i = 0; i < 5; i++) drop(32'hCF00_0000 + i, i == 4);
    repeat (3) @(negedge wclk);
    chk(wr_full == 1'b1, "R6", "full", wr_full, 1);
    chk(overflow == 1'b1, "R7", "overflow", overflow, 1);
    // R6: event offered while full is ignored
    drop(32'hDEAD_0000, 1'b0);
    drop(32'hDEAD_0001, 1'b1);
    repeat (6) @(negedge rclk);
    chk(ev_ready == 1'b1, "R4", "ready with truncated event", ev_ready, 1);
    chk(rd_valid == 1'b1, "R7", "truncated event readable", rd_valid, 1);
    reader_on = 1'b1;
    drain();
    chk(ev_ready == 1'b0, "R4", "ready after truncated drain", ev_ready, 0);
    chk(rd_empty == 1'b1, "R6", "dropped words absent", rd_empty, 1);
    chk(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);
    repeat (4) @(negedge wclk);
    chk(wr_full == 1'b0, "R6", "full released", wr_full, 0);

    // R8: traffic continues after overflow
    send_event(3, 32'hE000_0000);
    send_event(4, 32'hE100_0000);
    drain();
    chk(overflow == 1'b1, "R8", "overflow still set", overflow, 1);
    chk(exp_q.size() == 0, "R2", "queue empty", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule